// File: doc/BRIEF.md
# UART Transmit Path with Request Flag

This block is the send side of a serial port. Characters written by the host go either into a single holding register (holding mode) or into a 64-character queue (queue mode). A four-state serializer then shifts them out on the line as 8N1 frames. The bit timing comes from an external baud tick, and each bit lasts 16 ticks.

A request flag tells the host or a DMA engine when more data can be written. In holding mode the flag follows the handoff between the holding register and the serializer. In queue mode it follows a selectable fill threshold: half full or below, or fully empty. The flag raises an interrupt when the interrupt enable is set. It raises a DMA request when the DMA enable is set and queue mode is active. A transmitter-empty flag reports that nothing is stored and nothing is being shifted.

Serializer states and transitions:
- `TX_IDLE` → `TX_START` when a stored character is taken.
- `TX_START` → `TX_DATA` after 16 ticks.
- `TX_DATA` → `TX_STOP` after the eighth data bit has lasted 16 ticks.
- `TX_STOP` → `TX_IDLE` after 16 ticks.

Top module: `uart_tx_req`

## Requirements
- R1: After reset, `txd`=1, `tx_req`=1, `tx_empty`=1 and `fifo_on`=0; with both enables low, `irq` and `dma_req` are 0.
- R2: The line idles high. Each character goes out as one low start bit, then 8 data bits LSB first, then one high stop bit. Every bit lasts 16 baud ticks, and characters leave in the order they were accepted.
- R3: In holding mode (`fifo_on`=0), a write to the empty holding register drops `tx_req` in the cycle after the write. `tx_req` returns to 1 in the cycle after the character moves into the serializer. While the serializer is busy, a write keeps `tx_req` at 0 until the previous frame completes.
- R4: In holding mode, a write while the holding register is occupied is discarded and never transmitted.
- R5: In queue mode with `lvl_empty`=0, `tx_req` is 1 exactly when the queue holds 32 or fewer characters. With `lvl_empty`=1, `tx_req` is 1 only when the queue is empty.
- R6: The queue holds 64 characters. A write while it is full is discarded and never transmitted.
- R7: `tx_empty` is 1 only when no character is stored and the serializer is idle. It stays 0 while the last frame is shifting, even though `tx_req` may already be 1.
- R8: A one-cycle pulse on `fifo_clr` discards all stored characters and sets `tx_req` in the next cycle. A frame already shifting completes.
- R9: `irq` equals `tx_req` while `req_irq_en`=1 and is 0 while `req_irq_en`=0.
- R10: `dma_req` equals `tx_req` only while `dma_en`=1 and queue mode is active. Otherwise it is 0.
- R11: `fifo_on` follows `fifo_en` one cycle later. Changing `fifo_en` discards all stored characters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to send |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects holding mode |
| fifo_clr | input | 1 | Pulse that empties the store |
| lvl_empty | input | 1 | Queue threshold: 0 = half or less, 1 = empty |
| req_irq_en | input | 1 | Interrupt enable for the request flag |
| dma_en | input | 1 | DMA request enable |
| baud_tick | input | 1 | One pulse per 1/16 bit time |
| txd | output | 1 | Serial line |
| tx_req | output | 1 | Data request flag |
| tx_empty | output | 1 | Transmitter-empty flag |
| irq | output | 1 | Interrupt |
| dma_req | output | 1 | DMA request |
| fifo_on | output | 1 | Queue mode status |

## Verification
The hardest case to reach is the full queue with the serializer busy. Only then can the 32/33 threshold boundary and the drop of writes to a full queue be observed, before draining moves the count. The stimulus starts one character so that the serializer is locked into a 320-cycle frame. It then writes 66 characters back to back within that window. A scoreboard of accepted characters confirms that the two excess characters never reach the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/tx_store.sv
module tx_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              deep_mode,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CW-1:0]     level
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     cap;
    logic              accept, take;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign cap    = deep_mode ? CW'(DEPTH) : CW'(1);
    assign accept = push && (level < cap);
    assign take   = pop && (level != '0);

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (accept) wr_ptr <= step(wr_ptr);
            if (take)   rd_ptr <= step(rd_ptr);
            unique case ({accept, take})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept && !flush) mem[wr_ptr] <= push_data;
    end

    assign pop_data = mem[rd_ptr];

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    assert_holding_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !deep_mode |-> level <= CW'(1));
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TICKS  = 16,
    localparam int TW    = $clog2(TICKS),
    localparam int BW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              take,
    output logic              txd,
    output logic              idle
);
    tx_state_e         state_q, state_d;
    logic [TW-1:0]     tick_q;
    logic [BW-1:0]     bit_q;
    logic [DATA_W-1:0] shreg;
    logic              bit_end;

    assign bit_end = baud_tick && (tick_q == TW'(TICKS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (in_valid) state_d = TX_START;
            TX_START: if (bit_end)  state_d = TX_DATA;
            TX_DATA:  if (bit_end && bit_q == BW'(DATA_W - 1)) state_d = TX_STOP;
            TX_STOP:  if (bit_end)  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            bit_q  <= '0;
            shreg  <= '0;
        end else begin
            if (state_q == TX_IDLE)  tick_q <= '0;
            else if (baud_tick)      tick_q <= bit_end ? '0 : tick_q + TW'(1);
            if (state_q == TX_START) bit_q <= '0;
            else if (state_q == TX_DATA && bit_end) bit_q <= bit_q + BW'(1);
            if (take) shreg <= in_data;
            else if (state_q == TX_DATA && bit_end) shreg <= shreg >> 1;
        end
    end

    always_comb begin
        txd  = 1'b1;
        idle = 1'b0;
        take = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                idle = 1'b1;
                take = in_valid;
            end
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_STOP:  txd = 1'b1;
        endcase
    end

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !txd);
endmodule

// File: rtl/tx_req_gen.sv
module tx_req_gen #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic          deep_mode,
    input  logic          lvl_empty,
    input  logic [CW-1:0] level,
    input  logic          irq_en,
    input  logic          dma_en,
    output logic          req,
    output logic          irq,
    output logic          dma
);
    logic is_empty, at_half;

    assign is_empty = (level == '0);
    assign at_half  = (level <= CW'(HALF));

    always_comb begin
        unique case ({deep_mode, lvl_empty})
            2'b10:   req = at_half;
            2'b11:   req = is_empty;
            default: req = is_empty;
        endcase
        irq = req && irq_en;
        dma = req && dma_en && deep_mode;
    end
endmodule

// File: rtl/uart_tx_req.sv
module uart_tx_req #(
    parameter int DATA_W        = 8,
    parameter int DEPTH         = 64,
    parameter int TICKS_PER_BIT = 16,
    localparam int CW           = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fifo_en,
    input  logic              fifo_clr,
    input  logic              lvl_empty,
    input  logic              req_irq_en,
    input  logic              dma_en,
    input  logic              baud_tick,
    output logic              txd,
    output logic              tx_req,
    output logic              tx_empty,
    output logic              irq,
    output logic              dma_req,
    output logic              fifo_on
);
    logic              mode_q, flush, sh_valid, sh_take, sh_idle;
    logic [CW-1:0]     level;
    logic [DATA_W-1:0] head;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= fifo_en;
    end

    assign flush    = fifo_clr || (fifo_en != mode_q);
    assign sh_valid = (level != '0) && !flush;
    assign fifo_on  = mode_q;
    assign tx_empty = sh_idle && (level == '0);

    tx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .deep_mode (mode_q),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (sh_take),
        .pop_data  (head),
        .level     (level)
    );

    tx_serializer #(.DATA_W(DATA_W), .TICKS(TICKS_PER_BIT)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .in_valid  (sh_valid),
        .in_data   (head),
        .take      (sh_take),
        .txd       (txd),
        .idle      (sh_idle)
    );

    tx_req_gen #(.DEPTH(DEPTH)) u_req (
        .deep_mode (mode_q),
        .lvl_empty (lvl_empty),
        .level     (level),
        .irq_en    (req_irq_en),
        .dma_en    (dma_en),
        .req       (tx_req),
        .irq       (irq),
        .dma       (dma_req)
    );

    assert_clear_sets_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> tx_req);

    assert_idle_line_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);
endmodule

// File: tb/test_uart_tx_req.sv
`timescale 1ns/1ps
module test_uart_tx_req;
    logic clk = 0, rst_n = 0;
    logic wr_en = 0, fifo_en = 0, fifo_clr = 0, lvl_empty = 0;
    logic req_irq_en = 0, dma_en = 0, baud_tick = 0;
    logic [7:0] wr_data = 0;
    logic txd, tx_req, tx_empty, irq, dma_req, fifo_on;
    int   errors = 0, checks = 0;
    bit   done = 0;
    logic [7:0] expq [$];

    always #4 clk = ~clk;

    uart_tx_req i_uart_tx_req (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_en(fifo_en), .fifo_clr(fifo_clr), .lvl_empty(lvl_empty),
        .req_irq_en(req_irq_en), .dma_en(dma_en), .baud_tick(baud_tick),
        .txd(txd), .tx_req(tx_req), .tx_empty(tx_empty), .irq(irq),
        .dma_req(dma_req), .fifo_on(fifo_on));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] b, input bit expect_sent);
        @(negedge clk);
        wr_en = 1; wr_data = b;
        @(negedge clk);
        wr_en = 0;
        if (expect_sent) expq.push_back(b);
    endtask

    task automatic wait_req();
        for (int n = 0; n < 30000 && !tx_req; n++) @(negedge clk);
    endtask

    task automatic wait_empty();
        for (int n = 0; n < 2000 && !tx_empty; n++) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            baud_tick = ~baud_tick;
        end
    end

    // monitor: decode frames, compare with scoreboard queue (R2)
    initial begin
        logic [7:0] got;
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                repeat (16) @(negedge clk);
                check("R2 start bit", {7'd0, txd}, 8'd0);
                for (int b = 0; b < 8; b++) begin
                    repeat (32) @(negedge clk);
                    got[b] = txd;
                end
                repeat (32) @(negedge clk);
                check("R2 stop bit", {7'd0, txd}, 8'd1);
                if (expq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 unexpected char: got %0h expected none", got);
                end else begin
                    check("R2 char", got, expq.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 txd", {7'd0, txd}, 8'd1);
        check("R1 tx_req", {7'd0, tx_req}, 8'd1);
        check("R1 tx_empty", {7'd0, tx_empty}, 8'd1);
        check("R1 fifo_on", {7'd0, fifo_on}, 8'd0);
        check("R1 irq", {7'd0, irq}, 8'd0);
        check("R1 dma_req", {7'd0, dma_req}, 8'd0);

        // holding mode
        req_irq_en = 1; dma_en = 1;
        do_write(8'hA5, 1);
        check("R3 req clears on write", {7'd0, tx_req}, 8'd0);
        check("R9 irq follows req", {7'd0, irq}, 8'd0);
        @(negedge clk);
        check("R3 req sets on move", {7'd0, tx_req}, 8'd1);
        check("R9 irq enabled", {7'd0, irq}, 8'd1);
        check("R10 no dma in holding", {7'd0, dma_req}, 8'd0);
        do_write(8'h3C, 1);
        check("R3 req held low while busy", {7'd0, tx_req}, 8'd0);
        do_write(8'hFF, 0);
        check("R4 req still low after dropped", {7'd0, tx_req}, 8'd0);
        check("R7 not empty", {7'd0, tx_empty}, 8'd0);
        wait_req();
        check("R3 req after frame", {7'd0, tx_req}, 8'd1);
        check("R7 busy last frame", {7'd0, tx_empty}, 8'd0);
        req_irq_en = 0;
        @(negedge clk);
        check("R9 irq disabled", {7'd0, irq}, 8'd0);
        wait_empty();
        check("R4 holding drained", 8'(expq.size()), 8'd0);

        // queue mode
        fifo_en = 1;
        @(negedge clk);
        check("R11 fifo_on", {7'd0, fifo_on}, 8'd1);
        check("R10 dma in queue mode", {7'd0, dma_req}, 8'd1);
        do_write(8'h11, 1);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 32; i++) do_write(8'(i * 37 + 5), 1);
        check("R5 req at 32", {7'd0, tx_req}, 8'd1);
        do_write(8'hC3, 1);
        check("R5 req at 33", {7'd0, tx_req}, 8'd0);
        for (int i = 0; i < 31; i++) do_write(8'(i * 13 + 100), 1);
        do_write(8'hEE, 0);
        do_write(8'hDD, 0);
        check("R6 req low when full", {7'd0, tx_req}, 8'd0);
        lvl_empty = 1;
        @(negedge clk);
        check("R5 empty level", {7'd0, tx_req}, 8'd0);
        wait_req();
        check("R5 req when empty", {7'd0, tx_req}, 8'd1);
        check("R7 shifting last", {7'd0, tx_empty}, 8'd0);
        dma_en = 0;
        @(negedge clk);
        check("R10 dma disabled", {7'd0, dma_req}, 8'd0);
        wait_empty();
        check("R6 queue drained", 8'(expq.size()), 8'd0);
        check("R7 idle line", {7'd0, txd}, 8'd1);

        // clear pulse
        do_write(8'h5A, 1);
        repeat (3) @(negedge clk);
        do_write(8'h77, 0);
        do_write(8'h88, 0);
        check("R8 req low before clear", {7'd0, tx_req}, 8'd0);
        fifo_clr = 1;
        @(negedge clk);
        fifo_clr = 0;
        check("R8 req after clear", {7'd0, tx_req}, 8'd1);
        wait_empty();
        check("R8 cleared not sent", 8'(expq.size()), 8'd0);

        // mode switch discards
        do_write(8'h69, 1);
        repeat (3) @(negedge clk);
        do_write(8'h96, 0);
        check("R11 req low before switch", {7'd0, tx_req}, 8'd0);
        fifo_en = 0;
        @(negedge clk);
        check("R11 fifo_on off", {7'd0, fifo_on}, 8'd0);
        check("R11 req after switch", {7'd0, tx_req}, 8'd1);
        wait_empty();
        check("R11 discarded not sent", 8'(expq.size()), 8'd0);
        check("R7 final empty", {7'd0, tx_empty}, 8'd1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule